// File: doc/BRIEF.md
# Passive Configuration Worm Router

This block sits beside one tile of a reconfigurable fabric and moves configuration worms. A worm is a head flit, any number of body flits, and a tail flit. Worms arrive on up to four neighbour inputs and leave on the matching neighbour outputs or on a local output that feeds the tile's own configuration chain. The router never chooses a path by itself. It reads a 3-bit direction code from the head, binds the input to that output, and keeps the binding until the tail has passed.

Forwarding is cut-through with no storage: a granted flit appears on its output in the same cycle it is presented. Worms that want different outputs move in parallel. A worm whose output is already bound, or is lost to a higher-priority head, is stalled by holding its input ready low. Before the head leaves, the router removes its own direction code, so the next router finds its code in the low bits. A parameter builds the router with four neighbour ports for an interior tile or three for an edge tile.

Top module: `cfg_worm_router`

## Requirements
- R1: After reset no input is bound, and with all inputs idle no output is valid.
- R2: A flit's kind is held in its top two bits: 00 idle, 01 head, 10 body, 11 tail. A head carries its direction code in payload bits [2:0]. Codes 0, 1, 2 and 3 select the north, east, south and west outputs (indices 0 to 3). Code 4, codes 5 to 7, and any code naming a port that is not built all select the local output, index NUM_PORTS.
- R3: A granted flit appears on its output in the same cycle, and the output valid equals that input's valid. An output is never driven by two inputs at once.
- R4: When several unbound heads request the same free output in one cycle, the lowest-numbered input wins. The losing inputs see ready low.
- R5: An output stays bound to its input from the cycle the head transfers through the cycle the tail transfers. Other heads for that output stall for the whole time. The binding is released at the tail's transfer edge, so a waiting head can win in the next cycle.
- R6: A granted or bound input's ready follows the ready of its output. A stalled input's ready is low.
- R7: A forwarded head has its payload shifted right by three bits, with zeros filled in at the top. Body and tail payloads, and every flit kind, pass unchanged.
- R8: An idle, body or tail flit on an unbound input is accepted (ready high) and dropped without making any output valid.
- R9: Worms bound for different outputs transfer in the same cycle.
- R10: NUM_PORTS selects a 4-port or a 3-port router. In the 3-port build, code 3 selects the local output, index 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | NUM_PORTS | Flit valid per neighbour input |
| in_flit_i | input | NUM_PORTS x (DATA_W+2) | Flit per input: kind in the top two bits, payload below |
| in_ready_o | output | NUM_PORTS | Flit accepted on this input this cycle |
| out_valid_o | output | NUM_PORTS+1 | Flit valid per output; the last index is local |
| out_flit_o | output | (NUM_PORTS+1) x (DATA_W+2) | Forwarded flit per output |
| out_ready_i | input | NUM_PORTS+1 | Downstream can take a flit on this output |

## Verification
The checks assume that every input sends well-formed worms: a head, then bodies, then a tail, with no second head before the tail. They also assume each input holds a flit until it is accepted. The random stimulus builds worms from a per-input generator that only moves on after a transfer. Stray idle, body and tail flits are sent only between worms, which is where the router is defined to drop them. Downstream readiness is random on every output. No routing loop exists, so no stall can last.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;
  typedef enum logic [1:0] {
    FK_IDLE = 2'b00,
    FK_HEAD = 2'b01,
    FK_BODY = 2'b10,
    FK_TAIL = 2'b11
  } flit_kind_e;

  localparam int unsigned CODE_W = 3;
endpackage

// File: rtl/cfg_route_decode.sv
module cfg_route_decode
  import cfg_router_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned DATA_W    = 16,
  localparam int unsigned FLIT_W    = DATA_W + 2,
  localparam int unsigned NUM_OUT   = NUM_PORTS + 1,
  localparam int unsigned OUT_IDX_W = $clog2(NUM_OUT)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [FLIT_W-1:0]    flit_i,
  input  logic                 xfer_i,
  output logic                 head_req_o,
  output logic                 bound_o,
  output logic [OUT_IDX_W-1:0] sel_o,
  output logic [FLIT_W-1:0]    fwd_flit_o
);
  flit_kind_e           kind;
  logic [CODE_W-1:0]    code;
  logic [OUT_IDX_W-1:0] tgt;
  logic                 bound_q;
  logic [OUT_IDX_W-1:0] dir_q;

  assign kind = flit_kind_e'(flit_i[FLIT_W-1 -: 2]);
  assign code = flit_i[CODE_W-1:0];

  // absent or out-of-range directions fall through to the local port
  always_comb begin
    if (32'(code) < NUM_PORTS) tgt = OUT_IDX_W'(code);
    else                       tgt = OUT_IDX_W'(NUM_PORTS);
  end

  assign head_req_o = valid_i && (kind == FK_HEAD) && !bound_q;
  assign bound_o    = bound_q;
  assign sel_o      = bound_q ? dir_q : tgt;

  // pop this hop's direction code so the next router sees its own
  assign fwd_flit_o = head_req_o ? {flit_i[FLIT_W-1 -: 2], flit_i[DATA_W-1:0] >> CODE_W}
                                 : flit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bound_q <= 1'b0;
      dir_q   <= '0;
    end else if (xfer_i) begin
      if (head_req_o) begin
        bound_q <= 1'b1;
        dir_q   <= tgt;
      end else if (bound_q && kind == FK_TAIL) begin
        bound_q <= 1'b0;
      end
    end
  end

  // R5
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound_q && !(xfer_i && kind == FK_TAIL) |=> bound_q && $stable(dir_q));
  // R5
  lock_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound_q && xfer_i && kind == FK_TAIL |=> !bound_q);
  // R7
  head_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_req_o |-> fwd_flit_o[DATA_W-1 -: CODE_W] == '0);
endmodule

// File: rtl/cfg_prio_arb.sv
module cfg_prio_arb #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  // lowest set bit wins
  assign grant_o = req_i & (~req_i + N'(1));
endmodule

// File: rtl/cfg_worm_router.sv
module cfg_worm_router
  import cfg_router_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned DATA_W    = 16,
  localparam int unsigned FLIT_W    = DATA_W + 2,
  localparam int unsigned NUM_OUT   = NUM_PORTS + 1,
  localparam int unsigned OUT_IDX_W = $clog2(NUM_OUT)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_PORTS-1:0]              in_valid_i,
  input  logic [NUM_PORTS-1:0][FLIT_W-1:0]  in_flit_i,
  output logic [NUM_PORTS-1:0]              in_ready_o,
  output logic [NUM_OUT-1:0]                out_valid_o,
  output logic [NUM_OUT-1:0][FLIT_W-1:0]    out_flit_o,
  input  logic [NUM_OUT-1:0]                out_ready_i
);
  logic [NUM_PORTS-1:0]                 head_req, bound, granted, xfer;
  logic [NUM_PORTS-1:0][OUT_IDX_W-1:0]  sel;
  logic [NUM_PORTS-1:0][FLIT_W-1:0]     fwd_flit;
  logic [NUM_OUT-1:0][NUM_PORTS-1:0]    hold, req, win, conn;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_in
    cfg_route_decode #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_dec (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .valid_i    (in_valid_i[p]),
      .flit_i     (in_flit_i[p]),
      .xfer_i     (xfer[p]),
      .head_req_o (head_req[p]),
      .bound_o    (bound[p]),
      .sel_o      (sel[p]),
      .fwd_flit_o (fwd_flit[p])
    );
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic                 locked;
    logic [NUM_PORTS-1:0] arb_req;
    logic [FLIT_W-1:0]    mux_flit;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_map
      assign hold[o][p] = bound[p] && (sel[p] == OUT_IDX_W'(o));
      assign req[o][p]  = head_req[p] && (sel[p] == OUT_IDX_W'(o));
    end

    assign locked  = |hold[o];
    assign arb_req = locked ? '0 : req[o];

    cfg_prio_arb #(.N(NUM_PORTS)) u_arb (
      .req_i   (arb_req),
      .grant_o (win[o])
    );

    assign conn[o]        = hold[o] | win[o];
    assign out_valid_o[o] = |(conn[o] & in_valid_i);

    always_comb begin
      mux_flit = '0;
      for (int p = 0; p < NUM_PORTS; p++)
        if (conn[o][p]) mux_flit |= fwd_flit[p];
    end
    assign out_flit_o[o] = mux_flit;

    // R3
    one_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(conn[o]));
    // R5
    lock_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(hold[o]) <= 1);
    // R4
    arb_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|arb_req) |-> $onehot(win[o]));
  end

  always_comb begin
    granted = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      for (int o = 0; o < NUM_OUT; o++)
        if (conn[o][p]) granted[p] = 1'b1;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rdy
    // unbound non-head flits are swallowed
    assign in_ready_o[p] = (!bound[p] && !head_req[p]) ? 1'b1
                         : (granted[p] && out_ready_i[sel[p]]);
    assign xfer[p] = in_valid_i[p] && in_ready_o[p];

    // R6
    backpressure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i[p] && bound[p] && !out_ready_i[sel[p]] |-> !in_ready_o[p]);
    // R8
    stray_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i[p] && !bound[p] && !head_req[p] |-> !granted[p] && in_ready_o[p]);
  end
endmodule

// File: tb/cfg_worm_router_test.sv
`timescale 1ns/1ps
module cfg_worm_router_test;
  localparam int NP = 4;
  localparam int DW = 16;
  localparam int NO = NP + 1;
  localparam int FW = DW + 2;
  localparam logic [1:0] K_IDLE = 2'b00, K_HEAD = 2'b01, K_BODY = 2'b10, K_TAIL = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NP-1:0]         in_valid;
  logic [NP-1:0][FW-1:0] in_flit;
  logic [NP-1:0]         in_ready;
  logic [NO-1:0]         out_valid;
  logic [NO-1:0][FW-1:0] out_flit;
  logic [NO-1:0]         out_ready;

  logic [2:0]        in3_valid;
  logic [2:0][FW-1:0] in3_flit;
  logic [2:0]        in3_ready;
  logic [3:0]        out3_valid;
  logic [3:0][FW-1:0] out3_flit;
  logic [3:0]        out3_ready;

  cfg_worm_router #(.NUM_PORTS(NP), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_flit_i(in_flit), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_flit_o(out_flit), .out_ready_i(out_ready));

  cfg_worm_router #(.NUM_PORTS(3), .DATA_W(DW)) uut_edge (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in3_valid), .in_flit_i(in3_flit), .in_ready_o(in3_ready),
    .out_valid_o(out3_valid), .out_flit_o(out3_flit), .out_ready_i(out3_ready));

  int checks = 0;
  int failures = 0;
  bit done = 0;

  bit            m_bound [NP];
  int            m_dir   [NP];
  bit            e_ready [NP];
  bit            e_valid [NO];
  logic [FW-1:0] e_flit  [NO];
  int            e_src   [NO];

  bit            rnd_mode = 0;
  bit            g_act  [NP];
  int            g_left [NP];
  int            g_plan [NP];
  bit            g_has  [NP];
  logic [FW-1:0] g_flit [NP];

  function automatic logic [FW-1:0] mk(logic [1:0] k, logic [DW-1:0] pl);
    return {k, pl};
  endfunction

  function automatic int tgt_of(logic [FW-1:0] f);
    int c = int'(f[2:0]);
    return (c < NP) ? c : NP;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compute();
    for (int o = 0; o < NO; o++) begin
      e_src[o] = -1;
      for (int p = 0; p < NP; p++)
        if (m_bound[p] && m_dir[p] == o) e_src[o] = p;
      if (e_src[o] < 0)
        for (int p = 0; p < NP; p++)
          if (e_src[o] < 0 && !m_bound[p] && in_valid[p] &&
              in_flit[p][FW-1:FW-2] == K_HEAD && tgt_of(in_flit[p]) == o)
            e_src[o] = p;
      e_valid[o] = 0;
      e_flit[o]  = '0;
      if (e_src[o] >= 0) begin
        int s = e_src[o];
        e_valid[o] = in_valid[s];
        if (!m_bound[s] && in_flit[s][FW-1:FW-2] == K_HEAD)
          e_flit[o] = {in_flit[s][FW-1:FW-2], in_flit[s][DW-1:0] >> 3};
        else
          e_flit[o] = in_flit[s];
      end
    end
    for (int p = 0; p < NP; p++) begin
      bit hd = in_valid[p] && in_flit[p][FW-1:FW-2] == K_HEAD;
      if (!m_bound[p] && !hd) e_ready[p] = 1;
      else begin
        int sl = m_bound[p] ? m_dir[p] : tgt_of(in_flit[p]);
        e_ready[p] = (e_src[sl] == p) ? bit'(out_ready[sl]) : 1'b0;
      end
    end
  endtask

  task automatic peek();
    #1;
  endtask

  task automatic finish_cycle();
    compute();
    for (int o = 0; o < NO; o++) begin
      chk(out_valid[o] == e_valid[o], "R3 out_valid", 64'(out_valid[o]), 64'(e_valid[o]));
      if (e_valid[o])
        chk(out_flit[o] == e_flit[o], "R7 out_flit", 64'(out_flit[o]), 64'(e_flit[o]));
    end
    for (int p = 0; p < NP; p++)
      if (in_valid[p])
        chk(in_ready[p] == e_ready[p], "R6 in_ready", 64'(in_ready[p]), 64'(e_ready[p]));
    for (int p = 0; p < NP; p++) begin
      if (in_valid[p] && e_ready[p]) begin
        logic [1:0] k = in_flit[p][FW-1:FW-2];
        if (!m_bound[p] && k == K_HEAD) begin
          m_bound[p] = 1;
          m_dir[p] = tgt_of(in_flit[p]);
        end else if (m_bound[p] && k == K_TAIL) m_bound[p] = 0;
        if (rnd_mode) begin
          g_has[p] = 0;
          if (k == K_HEAD && !g_act[p]) begin g_act[p] = 1; g_left[p] = g_plan[p]; end
          else if (g_act[p] && k == K_BODY) g_left[p]--;
          else if (g_act[p] && k == K_TAIL) g_act[p] = 0;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic idle_all();
    in_valid = '0;
    in_flit  = '0;
    out_ready = '1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int p = 0; p < NP; p++) begin
      m_bound[p] = 0; m_dir[p] = 0; g_act[p] = 0; g_has[p] = 0; g_left[p] = 0; g_plan[p] = 0;
    end
    idle_all();
    in3_valid = '0; in3_flit = '0; out3_ready = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek();
    chk(out_valid == '0, "R1 idle outputs", 64'(out_valid), 64'd0);
    chk(out3_valid == '0, "R1 idle outputs edge", 64'(out3_valid), 64'd0);
    finish_cycle();

    // R2 + R7: west input, code 1 -> east, head popped
    in_valid[3] = 1; in_flit[3] = mk(K_HEAD, 16'hABC1);
    in3_valid[0] = 1; in3_flit[0] = mk(K_HEAD, 16'h0003);
    peek();
    chk(out_valid == 5'b00010, "R2 code1 east", 64'(out_valid), 64'h02);
    chk(out_flit[1] == mk(K_HEAD, 16'h1578), "R7 head pop", 64'(out_flit[1]), 64'(mk(K_HEAD, 16'h1578)));
    // R10 edge build: code 3 -> local index 3
    chk(out3_valid == 4'b1000, "R10 edge local", 64'(out3_valid), 64'h8);
    finish_cycle();
    in_flit[3] = mk(K_TAIL, 16'h1234);
    in3_flit[0] = mk(K_TAIL, 16'h0000);
    peek();
    chk(out_flit[1] == mk(K_TAIL, 16'h1234), "R7 tail unchanged", 64'(out_flit[1]), 64'(mk(K_TAIL, 16'h1234)));
    finish_cycle();
    idle_all(); in3_valid = '0;

    // R2 local codes, R4 priority
    in_valid[0] = 1; in_flit[0] = mk(K_HEAD, 16'h0004);
    in_valid[1] = 1; in_flit[1] = mk(K_HEAD, 16'h0006);
    peek();
    chk(out_valid == 5'b10000, "R2 code4 local", 64'(out_valid), 64'h10);
    chk(in_ready[0] == 1 && in_ready[1] == 0, "R4 low index wins", 64'(in_ready[1:0]), 64'h1);
    finish_cycle();
    // R5: tail on p0; p1 still blocked this cycle
    in_flit[0] = mk(K_TAIL, 16'h00AA);
    peek();
    chk(in_ready[1] == 0, "R5 locked until tail edge", 64'(in_ready[1]), 64'h0);
    chk(out_flit[4] == mk(K_TAIL, 16'h00AA), "R5 owner keeps output", 64'(out_flit[4]), 64'(mk(K_TAIL, 16'h00AA)));
    finish_cycle();
    in_valid[0] = 0;
    peek();
    chk(in_ready[1] == 1 && out_valid[4] == 1, "R5 release next cycle", 64'({in_ready[1], out_valid[4]}), 64'h3);
    chk(out_flit[4] == mk(K_HEAD, 16'h0000), "R2 code6 local", 64'(out_flit[4]), 64'(mk(K_HEAD, 16'h0000)));
    finish_cycle();
    in_flit[1] = mk(K_TAIL, 16'h0001);
    peek(); finish_cycle();
    idle_all();

    // R6 back-pressure
    in_valid[2] = 1; in_flit[2] = mk(K_HEAD, 16'h0010); out_ready[0] = 0;
    peek();
    chk(in_ready[2] == 0 && out_valid[0] == 1, "R6 held head", 64'({in_ready[2], out_valid[0]}), 64'h1);
    finish_cycle();
    out_ready[0] = 1;
    peek(); finish_cycle();
    in_flit[2] = mk(K_BODY, 16'h5555); out_ready[0] = 0;
    peek();
    chk(in_ready[2] == 0, "R6 body stalled", 64'(in_ready[2]), 64'h0);
    finish_cycle();
    in_flit[2] = mk(K_TAIL, 16'h6666); out_ready[0] = 1;
    peek(); finish_cycle(); finish_cycle();
    peek(); finish_cycle();
    idle_all();

    // R8 stray flits dropped
    in_valid[0] = 1; in_flit[0] = mk(K_BODY, 16'h0001);
    in_valid[1] = 1; in_flit[1] = mk(K_IDLE, 16'h0002);
    peek();
    chk(in_ready[1:0] == 2'b11 && out_valid == '0, "R8 stray dropped",
        64'({in_ready[1:0], out_valid}), 64'({2'b11, 5'b0}));
    finish_cycle();
    idle_all();

    // R9 parallel worms
    in_valid[0] = 1; in_flit[0] = mk(K_HEAD, 16'h0001);
    in_valid[1] = 1; in_flit[1] = mk(K_HEAD, 16'h0003);
    peek();
    chk(out_valid == 5'b01010 && in_ready[1:0] == 2'b11, "R9 parallel",
        64'({in_ready[1:0], out_valid}), 64'({2'b11, 5'b01010}));
    finish_cycle();
    in_flit[0] = mk(K_TAIL, 16'h0); in_flit[1] = mk(K_TAIL, 16'h0);
    peek(); finish_cycle();
    idle_all();

    // random phase
    rnd_mode = 1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      for (int p = 0; p < NP; p++) begin
        if (!g_has[p]) begin
          logic [DW-1:0] pl = DW'($urandom);
          if (!g_act[p]) begin
            if ($urandom % 10 == 0) g_flit[p] = mk(($urandom % 2) ? K_BODY : K_IDLE, pl);
            else begin
              pl[2:0] = 3'($urandom % 8);
              g_flit[p] = mk(K_HEAD, pl);
              g_plan[p] = int'($urandom % 4);
            end
          end else g_flit[p] = mk((g_left[p] > 0) ? K_BODY : K_TAIL, pl);
          g_has[p] = 1;
        end
        in_flit[p]  = g_flit[p];
        in_valid[p] = ($urandom % 5 != 0);
      end
      for (int o = 0; o < NO; o++) out_ready[o] = ($urandom % 4 != 0);
      peek();
      finish_cycle();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule